// File: doc/BRIEF.md
# Channel Serial Transmitter with Test Payload Sources

This block is the per-channel serial output stage of a pulse-processing channel. It runs on a fast clock at eight times the bunch-crossing (BC) rate. At every frame boundary it captures one payload word and shifts it out one bit per fast cycle, least significant bit first. In normal operation a frame is eight bits, so one frame leaves per BC. The payload comes from one of four sources: the filtered energy byte, a constant register value, the low byte of a seedable 16-bit pseudo-random generator, or the upper eight bits of the raw ADC sample. The last three serve link and alignment tests.

When a raw-sample burst is requested, frames widen to ten bits and carry the complete ADC sample. A frame-size flag tells the receiver which width is on the line. A start-of-frame flag marks the first bit of every frame. A programmable coarse delay of zero to three whole BCs is applied to the serial bit and both flags together, so that channels with different pipeline latencies can be lined up. All channels share one generator step strobe, and each channel has its own seed, so several generators can be kept in lock-step.

The serial line cannot stall, so the block has no valid/ready handshake and no back-pressure. The payload inputs are level signals that upstream logic holds steady for the BC. They are sampled only on the fast edge that opens a frame, and what they carry at any other edge is ignored.

Top module: `txs_chan_tx`

## Requirements
- R1: The frame payload is chosen by `src_sel`, sampled on the frame-opening edge: 2'b00 energy byte, 2'b01 `const_val`, 2'b10 generator low byte, 2'b11 `adc_sample[9:2]`.
- R2: A pulse on `seed_wr` loads `seed_val` into the generator on the next fast edge, taking priority over a `prng_step` in the same cycle.
- R3: On each edge with `prng_step` high and no seed write, the 16-bit generator state q becomes {q[14:0], ~(q[15]^q[14]^q[12]^q[3])}. The one exception is the all-ones state, which goes to 16'hFFFE so that the sequence never sticks. Without a step or a seed write, the state holds. The state after reset is 16'h0001.
- R4: The generator payload is the generator's state bits [7:0] at the frame-opening edge.
- R5: In 8-bit mode a new frame opens every 8 fast cycles. Bits leave LSB first on `ser_o`, `sof_o` is high only while bit 0 is on the line, and `wide_o` is low.
- R6: If `raw_burst` is high on a frame-opening edge, that frame is 10 bits long and carries `adc_sample[9:0]` LSB first, regardless of `src_sel`. `wide_o` is high for every bit of that frame.
- R7: A change of `src_sel` or `raw_burst` during a frame does not affect the frame in flight. It takes effect at the next frame.
- R8: `coarse_dly` = c delays `ser_o`, `sof_o` and `wide_o` by exactly 8·c fast cycles (c = 0..3). Before the delay line fills, the outputs read 0.
- R9: During reset all outputs are 0. The first frame opens on the first fast edge after reset is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast clock, eight times the BC rate |
| rst_n | input | 1 | Active-low synchronous reset |
| src_sel | input | 2 | Payload source select (R1 encoding) |
| const_val | input | 8 | Constant test payload |
| energy | input | 8 | Filtered energy byte |
| adc_sample | input | 10 | Raw ADC sample |
| raw_burst | input | 1 | Request for 10-bit raw-sample frames |
| seed_wr | input | 1 | Generator seed load strobe |
| seed_val | input | 16 | Generator seed value |
| prng_step | input | 1 | Shared generator advance strobe |
| coarse_dly | input | 2 | Coarse delay in whole BCs |
| ser_o | output | 1 | Serial data, LSB first |
| sof_o | output | 1 | High while bit 0 of a frame is on the line |
| wide_o | output | 1 | High during 10-bit frames |

## Verification
The bench targets the cases where a design would most likely slip. If the mode decision were taken mid-frame, a burst request or select change arriving inside a frame would corrupt it, yielding a frame with mixed sources or a 10-bit frame cut short. The generator is seeded with all ones. A plain XNOR register would then repeat the same byte forever, and a seed written together with a step would show a state one step ahead. The coarse delay is checked at each nonzero setting from reset. A delay line with the wrong tap would move the first start-of-frame pulse by whole or partial BCs, and one that delayed only the data would misplace the flags.

// File: rtl/txs_pkg.sv
package txs_pkg;

  typedef enum logic [1:0] {
    SRC_ENERGY = 2'b00,
    SRC_CONST  = 2'b01,
    SRC_PRNG   = 2'b10,
    SRC_RAW    = 2'b11
  } src_e;

  typedef struct packed {
    logic bit_v;
    logic sof;
    logic wide;
  } line_t;

endpackage

// File: rtl/txs_prng.sv
module txs_prng #(
  parameter int          W        = 16,
  parameter int          OUT_W    = 8,
  parameter logic [15:0] SEED_RST = 16'h0001
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             seed_wr,
  input  logic [W-1:0]     seed_val,
  input  logic             step,
  output logic [W-1:0]     state_o,
  output logic [OUT_W-1:0] byte_o
);

  localparam logic [W-1:0] ALL_ONES = '1;
  localparam logic [W-1:0] ESCAPE   = {{(W-1){1'b1}}, 1'b0};

  logic [W-1:0] q;
  logic         fb;

  generate
    if (W == 16) begin : g_w16
      always_comb fb = ~(q[15] ^ q[14] ^ q[12] ^ q[3]);
    end else if (W == 8) begin : g_w8
      always_comb fb = ~(q[7] ^ q[5] ^ q[4] ^ q[3]);
    end else begin : g_wx
      always_comb fb = ~(q[W-1] ^ q[W-2]);
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      q <= SEED_RST[W-1:0];
    end else if (seed_wr) begin
      q <= seed_val;
    end else if (step) begin
      if (q == ALL_ONES) q <= ESCAPE;
      else               q <= {q[W-2:0], fb};
    end
  end

  assign state_o = q;
  assign byte_o  = q[OUT_W-1:0];

endmodule

// File: rtl/txs_framer.sv
module txs_framer
  import txs_pkg::*;
#(
  parameter int NARROW = 8,
  parameter int ADC_W  = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        src_sel,
  input  logic [NARROW-1:0] const_val,
  input  logic [NARROW-1:0] energy,
  input  logic [ADC_W-1:0]  adc_sample,
  input  logic [NARROW-1:0] prng_byte,
  input  logic              raw_burst,
  output line_t             line_o
);

  localparam int CNT_W = $clog2(ADC_W + 1);
  localparam logic [CNT_W-1:0] LAST_N = CNT_W'(NARROW - 1);
  localparam logic [CNT_W-1:0] LAST_W = CNT_W'(ADC_W - 1);

  logic [ADC_W-1:0] sh;
  logic [ADC_W-1:0] payload;
  logic [CNT_W-1:0] cnt;
  logic             wide_r;
  logic             at_end;

  always_comb begin
    payload = '0;
    if (raw_burst) begin
      payload = adc_sample;
    end else begin
      unique case (src_e'(src_sel))
        SRC_ENERGY: payload = ADC_W'(energy);
        SRC_CONST:  payload = ADC_W'(const_val);
        SRC_PRNG:   payload = ADC_W'(prng_byte);
        SRC_RAW:    payload = ADC_W'(adc_sample[ADC_W-1 -: NARROW]);
        default:    payload = '0;
      endcase
    end
  end

  assign at_end = wide_r ? (cnt == LAST_W) : (cnt == LAST_N);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sh     <= '0;
      cnt    <= LAST_N;
      wide_r <= 1'b0;
    end else if (at_end) begin
      sh     <= payload;
      cnt    <= '0;
      wide_r <= raw_burst;
    end else begin
      sh     <= sh >> 1;
      cnt    <= cnt + 1'b1;
    end
  end

  assign line_o.bit_v = sh[0] & rst_n;
  assign line_o.sof   = (cnt == '0) & rst_n;
  assign line_o.wide  = wide_r;

endmodule

// File: rtl/txs_delay.sv
module txs_delay
  import txs_pkg::*;
#(
  parameter int MAX_BC = 3,
  parameter int BPB    = 8,
  localparam int CW    = $clog2(MAX_BC + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [CW-1:0] coarse,
  input  line_t         line_i,
  output line_t         line_o
);

  localparam int DEPTH = MAX_BC * BPB;

  line_t pipe [DEPTH];

  generate
    for (genvar s = 0; s < DEPTH; s++) begin : g_stage
      if (s == 0) begin : g_head
        always_ff @(posedge clk) begin
          if (!rst_n) pipe[s] <= '0;
          else        pipe[s] <= line_i;
        end
      end else begin : g_body
        always_ff @(posedge clk) begin
          if (!rst_n) pipe[s] <= '0;
          else        pipe[s] <= pipe[s-1];
        end
      end
    end
  endgenerate

  always_comb begin
    line_o = line_i;
    for (int b = 1; b <= MAX_BC; b++) begin
      if (coarse == CW'(b)) line_o = pipe[b*BPB-1];
    end
  end

endmodule

// File: rtl/txs_chan_tx.sv
module txs_chan_tx
  import txs_pkg::*;
#(
  parameter int NARROW = 8,
  parameter int ADC_W  = 10,
  parameter int PRNG_W = 16,
  parameter int MAX_BC = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        src_sel,
  input  logic [NARROW-1:0] const_val,
  input  logic [NARROW-1:0] energy,
  input  logic [ADC_W-1:0]  adc_sample,
  input  logic              raw_burst,
  input  logic              seed_wr,
  input  logic [PRNG_W-1:0] seed_val,
  input  logic              prng_step,
  input  logic [1:0]        coarse_dly,
  output logic              ser_o,
  output logic              sof_o,
  output logic              wide_o
);

  logic [PRNG_W-1:0] prng_q;
  logic [NARROW-1:0] prng_byte;
  line_t             f_line;
  line_t             d_line;

  txs_prng #(.W(PRNG_W), .OUT_W(NARROW)) u_prng (
    .clk      (clk),
    .rst_n    (rst_n),
    .seed_wr  (seed_wr),
    .seed_val (seed_val),
    .step     (prng_step),
    .state_o  (prng_q),
    .byte_o   (prng_byte)
  );

  txs_framer #(.NARROW(NARROW), .ADC_W(ADC_W)) u_framer (
    .clk        (clk),
    .rst_n      (rst_n),
    .src_sel    (src_sel),
    .const_val  (const_val),
    .energy     (energy),
    .adc_sample (adc_sample),
    .prng_byte  (prng_byte),
    .raw_burst  (raw_burst),
    .line_o     (f_line)
  );

  txs_delay #(.MAX_BC(MAX_BC), .BPB(NARROW)) u_delay (
    .clk    (clk),
    .rst_n  (rst_n),
    .coarse (coarse_dly),
    .line_i (f_line),
    .line_o (d_line)
  );

  assign ser_o  = d_line.bit_v;
  assign sof_o  = d_line.sof;
  assign wide_o = d_line.wide;

endmodule

// File: rtl/txs_chan_tx_chk.sv
module txs_chan_tx_chk #(
  parameter int BPB    = 8,
  parameter int WBITS  = 10,
  parameter int PRNG_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              f_sof,
  input logic              f_wide,
  input logic              sof_o,
  input logic [1:0]        coarse_dly,
  input logic              seed_wr,
  input logic [PRNG_W-1:0] seed_val,
  input logic              prng_step,
  input logic [PRNG_W-1:0] prng_q
);

  logic [4:0]     gap;
  logic           seen;
  logic [5:0]     calm;
  logic [1:0]     coarse_q;
  logic [BPB-1:0] hist;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      gap      <= '0;
      seen     <= 1'b0;
      calm     <= '0;
      coarse_q <= coarse_dly;
      hist     <= '0;
    end else begin
      gap      <= f_sof ? 5'd0 : gap + 5'd1;
      seen     <= seen | f_sof;
      coarse_q <= coarse_dly;
      calm     <= (coarse_dly != coarse_q) ? 6'd0 : ((calm == 6'd63) ? calm : calm + 6'd1);
      hist     <= {hist[BPB-2:0], f_sof};
    end
  end

  // R5 / R6: frames are spaced by their own length
  a_r5_frame_spacing: assert property (@(posedge clk) disable iff (!rst_n)
    (f_sof && seen) |-> (gap == ($past(f_wide) ? 5'(WBITS - 1) : 5'(BPB - 1))));

  // R6 / R7: the frame-size flag only moves when a frame opens
  a_r6_wide_stable: assert property (@(posedge clk) disable iff (!rst_n)
    !f_sof |-> $stable(f_wide));

  // R2: seed write wins and lands on the next edge
  a_r2_seed_load: assert property (@(posedge clk) disable iff (!rst_n)
    seed_wr |=> (prng_q == $past(seed_val)));

  // R3: a step always changes the state
  a_r3_not_stuck: assert property (@(posedge clk) disable iff (!rst_n)
    (prng_step && !seed_wr) |=> (prng_q != $past(prng_q)));

  // R3: without step or seed write the state holds
  a_r3_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!prng_step && !seed_wr) |=> $stable(prng_q));

  // R8: one-BC delay reproduces the start-of-frame pattern
  a_r8_one_bc_delay: assert property (@(posedge clk) disable iff (!rst_n)
    (coarse_dly == 2'd1 && calm >= 6'(BPB)) |-> (sof_o == hist[BPB-1]));

endmodule

bind txs_chan_tx txs_chan_tx_chk #(.BPB(NARROW), .WBITS(ADC_W), .PRNG_W(PRNG_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .f_sof      (f_line.sof),
  .f_wide     (f_line.wide),
  .sof_o      (sof_o),
  .coarse_dly (coarse_dly),
  .seed_wr    (seed_wr),
  .seed_val   (seed_val),
  .prng_step  (prng_step),
  .prng_q     (prng_q)
);

// File: tb/txs_chan_tx_test.sv
`timescale 1ns/1ps
module txs_chan_tx_test;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  src_sel = 2'b00;
  logic [7:0]  const_val = 8'h00;
  logic [7:0]  energy = 8'h00;
  logic [9:0]  adc_sample = 10'h000;
  logic        raw_burst = 1'b0;
  logic        seed_wr = 1'b0;
  logic [15:0] seed_val = 16'h0000;
  logic        prng_step = 1'b0;
  logic [1:0]  coarse_dly = 2'd0;
  logic        ser_o, sof_o, wide_o;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  logic [15:0] m = 16'h0001;
  bit          do_wr = 0, do_step = 0, do_mid = 0;
  logic [1:0]  mid_sel = 2'b00;
  logic        mid_burst = 1'b0;

  always #2 clk = ~clk;

  txs_chan_tx uut (
    .clk(clk), .rst_n(rst_n), .src_sel(src_sel), .const_val(const_val),
    .energy(energy), .adc_sample(adc_sample), .raw_burst(raw_burst),
    .seed_wr(seed_wr), .seed_val(seed_val), .prng_step(prng_step),
    .coarse_dly(coarse_dly), .ser_o(ser_o), .sof_o(sof_o), .wide_o(wide_o)
  );

  // {sel, const, energy, adc, burst, expected payload}
  localparam logic [38:0] VEC [10] = '{
    {2'd0, 8'h3C, 8'hA5, 10'h2B7, 1'b0, 10'h0A5},
    {2'd1, 8'h3C, 8'hA5, 10'h2B7, 1'b0, 10'h03C},
    {2'd3, 8'h3C, 8'hA5, 10'h2B7, 1'b0, 10'h0AD},
    {2'd0, 8'h3C, 8'h01, 10'h2B7, 1'b0, 10'h001},
    {2'd0, 8'h3C, 8'h01, 10'h2B7, 1'b1, 10'h2B7},
    {2'd1, 8'h3C, 8'h01, 10'h301, 1'b1, 10'h301},
    {2'd1, 8'h80, 8'h01, 10'h301, 1'b0, 10'h080},
    {2'd3, 8'h80, 8'h01, 10'h3FF, 1'b0, 10'h0FF},
    {2'd0, 8'h80, 8'h01, 10'h000, 1'b1, 10'h000},
    {2'd0, 8'h80, 8'hFF, 10'h000, 1'b0, 10'h0FF}
  };

  function automatic logic [15:0] lfsr_next(input logic [15:0] q);
    if (q == 16'hFFFF) return 16'hFFFE;
    return {q[14:0], ~(q[15] ^ q[14] ^ q[12] ^ q[3])};
  endfunction

  task automatic check(input bit ok, input string req, input logic [15:0] got, input logic [15:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check({ser_o, sof_o, wide_o} === 3'b000, "R9 reset outputs", {13'd0, ser_o, sof_o, wide_o}, 16'h0);
    m = 16'h0001;
    rst_n = 1'b1;
  endtask

  // Called at the negedge just before a frame-opening edge.
  task automatic run_frame(input logic [9:0] exp, input int w, input string req);
    logic [9:0] got;
    bit flg_ok;
    got = '0;
    flg_ok = 1;
    for (int i = 0; i < w; i++) begin
      @(posedge clk);
      @(negedge clk);
      got[i] = ser_o;
      if (sof_o !== (i == 0)) flg_ok = 0;
      if (wide_o !== (w == 10)) flg_ok = 0;
      if (i == 0) begin
        seed_wr   = do_wr;
        prng_step = do_step;
        if (do_wr)        m = seed_val;
        else if (do_step) m = lfsr_next(m);
      end
      if (i == 1) begin
        seed_wr   = 1'b0;
        prng_step = 1'b0;
      end
      if (i == 3 && do_mid) begin
        src_sel   = mid_sel;
        raw_burst = mid_burst;
      end
    end
    check(got === exp && flg_ok, req, {6'd0, got}, {6'd0, exp});
    do_wr = 0; do_step = 0; do_mid = 0;
  endtask

  task automatic delay_case(input logic [1:0] c);
    bit quiet;
    logic [7:0] got;
    bit flg_ok;
    coarse_dly = c;
    src_sel = 2'd1; const_val = 8'hA5; raw_burst = 1'b0;
    do_reset();
    quiet = 1;
    for (int e = 0; e < 8 * c; e++) begin
      @(posedge clk); @(negedge clk);
      if (ser_o | sof_o | wide_o) quiet = 0;
    end
    got = '0; flg_ok = 1;
    for (int i = 0; i < 8; i++) begin
      @(posedge clk); @(negedge clk);
      got[i] = ser_o;
      if (sof_o !== (i == 0) || wide_o !== 1'b0) flg_ok = 0;
    end
    check(quiet && flg_ok && got === 8'hA5, "R8 coarse delay", {6'd0, c, got}, {6'd0, c, 8'hA5});
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    do_reset();

    // R1 R5 R6 R9: table walk, first frame opens on first edge after reset
    for (int n = 0; n < 10; n++) begin
      src_sel    = VEC[n][38:37];
      const_val  = VEC[n][36:29];
      energy     = VEC[n][28:21];
      adc_sample = VEC[n][20:11];
      raw_burst  = VEC[n][10];
      run_frame(VEC[n][9:0], VEC[n][10] ? 10 : 8, "R1/R5/R6 table vector");
    end

    // R7: select changed mid-frame affects only the next frame
    src_sel = 2'd1; const_val = 8'h5A; energy = 8'hC3; raw_burst = 1'b0;
    do_mid = 1; mid_sel = 2'd0; mid_burst = 1'b0;
    run_frame(10'h05A, 8, "R7 select held in frame");
    run_frame(10'h0C3, 8, "R7 select applied next frame");

    // R7: burst raised mid-frame keeps current frame 8 bits
    adc_sample = 10'h1E6;
    do_mid = 1; mid_sel = 2'd0; mid_burst = 1'b1;
    run_frame(10'h0C3, 8, "R7 burst held in frame");
    run_frame(10'h1E6, 10, "R6 burst frame");
    raw_burst = 1'b0;
    run_frame(10'h0C3, 8, "R6 back to narrow");

    // R2 R3 R4: generator
    src_sel = 2'd2;
    run_frame({2'b00, m[7:0]}, 8, "R4 reset state payload");
    seed_val = 16'h1234; do_wr = 1;
    run_frame({2'b00, m[7:0]}, 8, "R4 payload before seed");
    run_frame({2'b00, m[7:0]}, 8, "R2 seed payload");
    for (int k = 0; k < 3; k++) begin
      do_step = 1;
      run_frame({2'b00, m[7:0]}, 8, "R3 step sequence");
    end
    run_frame({2'b00, m[7:0]}, 8, "R3 stepped payload");
    seed_val = 16'hFFFF; do_wr = 1;
    run_frame({2'b00, m[7:0]}, 8, "R2 before all-ones seed");
    for (int k = 0; k < 4; k++) begin
      do_step = 1;
      run_frame({2'b00, m[7:0]}, 8, "R3 all-ones escape");
    end
    run_frame({2'b00, m[7:0]}, 8, "R3 after escape");
    seed_val = 16'h00F0; do_wr = 1; do_step = 1;
    run_frame({2'b00, m[7:0]}, 8, "R2 seed with step");
    run_frame(10'h0F0, 8, "R2 seed beats step");
    run_frame(10'h0F0, 8, "R3 holds without step");

    // R8: coarse delay settings
    delay_case(2'd1);
    delay_case(2'd2);
    delay_case(2'd3);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

endmodule